// File: doc/BRIEF.md
# Fence-Register Access Guard

This block sits between one processor core and its bus in a statically partitioned many-core system. The core runs a single partition alongside the hypervisor. Every address the core issues is passed through untouched; the guard only decides whether the request may go on. A user-mode request is allowed when its address falls inside the partition's memory segment or inside one of its enabled I/O windows. Each segment and each window is described by a lower and an upper fence, at full byte resolution. Supervisor-mode requests skip the check altogether.

A request that fails the check is held back from the bus. It raises a one-cycle invalid-access exception for the hypervisor, and the first such failure is recorded in a sticky fault record. Fence values, the I/O window enables and the fault clear are set through a configuration port, and that port acts only on writes flagged as privileged. The fault record is a two-state machine. In state CLEAN nothing has been recorded; the transition "capture" moves it to HELD on a violation. In HELD the record is frozen. The transition "release" returns it to CLEAN on a privileged clear. The transition "recapture" keeps it in HELD, with the new fault's address and type, when a clear and a violation fall in the same cycle.

Top module: `fence_guard`

## Requirements
- R1: `bus_addr` always equals `req_addr`, and `bus_valid` is never high unless `req_valid` is high.
- R2: A user request is inside the memory segment when mem_lo <= addr < mem_hi, compared at full byte resolution with no alignment.
- R3: A pair whose upper fence is not greater than its lower fence matches nothing. After reset both memory fences are 0 and all I/O windows are disabled, so every user request is refused.
- R4: I/O window k (k from 0 to NIO-1) matches when its enable bit k is set and io_lo[k] <= addr < io_hi[k]. A disabled window matches nothing.
- R5: A request with `req_super` high is always forwarded (`bus_valid` equals `req_valid`) and never faults.
- R6: A user request that matches no window is refused in the same cycle (`bus_valid` low). `exc_pulse` is high during exactly the next cycle. This applies to reads (kind 00), writes (kind 01) and fetches (kind 10) alike.
- R7: The first refused request sets `flt_sticky` and records its address in `flt_addr` and its kind in `flt_kind`. Later violations leave the record unchanged while `flt_sticky` is set.
- R8: A privileged write to select 3 clears `flt_sticky` on the next cycle. If a violation occurs in the same cycle as the clear, the new violation is recorded instead and `flt_sticky` stays set.
- R9: A configuration write with `cfg_priv` low changes no fence, no enable and no fault state.
- R10: Configuration selects are: 0 memory lower, 1 memory upper, 2 I/O enable mask (bit k enables window k), 3 fault clear, 4+2k window k lower, 5+2k window k upper. A privileged write takes effect for requests in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request valid |
| req_addr | input | AW | Core request address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_super | input | 1 | Request issued in supervisor mode |
| bus_valid | output | 1 | Forwarded request valid |
| bus_addr | output | AW | Forwarded address, unchanged |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Configuration write is privileged |
| cfg_sel | input | SEL_W | Configuration target select |
| cfg_wdata | input | AW | Configuration write data |
| exc_pulse | output | 1 | Invalid-access exception, one cycle |
| flt_sticky | output | 1 | A fault is recorded |
| flt_addr | output | AW | Address of the recorded fault |
| flt_kind | output | 2 | Kind of the recorded fault |

## Verification
Two functions can fall in the same cycle: a privileged fault clear and a new user-mode violation. The bench first leaves a fault recorded. It then drives the clear write and an out-of-segment request in one cycle. It judges the outcome from the ports: `flt_sticky` must stay high and `flt_addr` and `flt_kind` must show the new request, not the old one. A lone clear one cycle later must then drop the flag. The bench also lines up a configuration write with a request in one cycle and checks that the request is judged by the old fences.

// File: rtl/fence_pkg.sv
package fence_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10
    } acc_kind_t;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_HELD  = 1'b1
    } rec_state_t;

    localparam int SEL_MEM_LO = 0;
    localparam int SEL_MEM_HI = 1;
    localparam int SEL_IO_EN  = 2;
    localparam int SEL_CLEAR  = 3;
    localparam int SEL_IO_BASE = 4;
endpackage

// File: rtl/fence_regs.sv
module fence_regs #(
    parameter int AW    = 32,
    parameter int NIO   = 2,
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_priv,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [AW-1:0]           cfg_wdata,
    output logic [AW-1:0]           mem_lo,
    output logic [AW-1:0]           mem_hi,
    output logic [NIO-1:0]          io_en,
    output logic [NIO-1:0][AW-1:0]  io_lo,
    output logic [NIO-1:0][AW-1:0]  io_hi,
    output logic                    clr_fault
);
    import fence_pkg::*;

    logic wr_ok;
    assign wr_ok     = cfg_we && cfg_priv;
    assign clr_fault = wr_ok && (cfg_sel == SEL_W'(SEL_CLEAR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_lo <= '0;
            mem_hi <= '0;
            io_en  <= '0;
        end else if (wr_ok) begin
            if (cfg_sel == SEL_W'(SEL_MEM_LO)) mem_lo <= cfg_wdata;
            if (cfg_sel == SEL_W'(SEL_MEM_HI)) mem_hi <= cfg_wdata;
            if (cfg_sel == SEL_W'(SEL_IO_EN))  io_en  <= cfg_wdata[NIO-1:0];
        end
    end

    for (genvar g = 0; g < NIO; g++) begin : g_io
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                io_lo[g] <= '0;
                io_hi[g] <= '0;
            end else if (wr_ok) begin
                if (cfg_sel == SEL_W'(SEL_IO_BASE + 2*g))     io_lo[g] <= cfg_wdata;
                if (cfg_sel == SEL_W'(SEL_IO_BASE + 2*g + 1)) io_hi[g] <= cfg_wdata;
            end
        end
    end

    // R9: an unprivileged write leaves the fences untouched
    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> ($stable(mem_lo) && $stable(mem_hi) && $stable(io_en)));
endmodule

// File: rtl/fence_cmp.sv
module fence_cmp #(
    parameter int AW = 32
) (
    input  logic          enable,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);
    always_comb begin
        hit = enable && (addr >= lo) && (addr < hi);
    end
endmodule

// File: rtl/fault_record.sv
module fault_record #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          violation,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    kind,
    output logic          exc_pulse,
    output logic          sticky,
    output logic [AW-1:0] rec_addr,
    output logic [1:0]    rec_kind
);
    import fence_pkg::*;

    rec_state_t state_q, state_d;
    logic       take;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_CLEAN: begin
                if (violation) begin
                    state_d = ST_HELD;   // capture
                    take    = 1'b1;
                end
            end
            ST_HELD: begin
                if (clear && violation) begin
                    state_d = ST_HELD;   // recapture
                    take    = 1'b1;
                end else if (clear) begin
                    state_d = ST_CLEAN;  // release
                end
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_pulse <= 1'b0;
            rec_addr  <= '0;
            rec_kind  <= '0;
        end else begin
            exc_pulse <= violation;
            if (take) begin
                rec_addr <= addr;
                rec_kind <= kind;
            end
        end
    end

    assign sticky = (state_q == ST_HELD);

    // R6: every violation raises the exception in the next cycle
    a_r6_exc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> exc_pulse);
    // R7: the record is frozen while held and not cleared
    a_r7_record_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clear) |=> (sticky && $stable(rec_addr) && $stable(rec_kind)));
    // R8: clear without violation empties the record
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !violation) |=> !sticky);
endmodule

// File: rtl/fence_guard.sv
module fence_guard #(
    parameter int AW    = 32,
    parameter int NIO   = 2,
    parameter int SEL_W = $clog2(4 + 2*NIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_kind,
    input  logic             req_super,
    output logic             bus_valid,
    output logic [AW-1:0]    bus_addr,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic             exc_pulse,
    output logic             flt_sticky,
    output logic [AW-1:0]    flt_addr,
    output logic [1:0]       flt_kind
);
    localparam int NPAIR = NIO + 1;

    logic [AW-1:0]          mem_lo, mem_hi;
    logic [NIO-1:0]         io_en;
    logic [NIO-1:0][AW-1:0] io_lo, io_hi;
    logic                   clr_fault;
    logic [NPAIR-1:0]       hits;
    logic                   legal, violation;

    fence_regs #(.AW(AW), .NIO(NIO), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_lo(mem_lo), .mem_hi(mem_hi), .io_en(io_en),
        .io_lo(io_lo), .io_hi(io_hi), .clr_fault(clr_fault)
    );

    fence_cmp #(.AW(AW)) u_mem_cmp (
        .enable(1'b1), .addr(req_addr), .lo(mem_lo), .hi(mem_hi), .hit(hits[0])
    );

    for (genvar k = 0; k < NIO; k++) begin : g_iocmp
        fence_cmp #(.AW(AW)) u_io_cmp (
            .enable(io_en[k]), .addr(req_addr), .lo(io_lo[k]), .hi(io_hi[k]), .hit(hits[k+1])
        );
    end

    assign legal     = |hits;
    assign violation = req_valid && !req_super && !legal;
    assign bus_valid = req_valid && (req_super || legal);
    assign bus_addr  = req_addr;

    fault_record #(.AW(AW)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .violation(violation), .clear(clr_fault),
        .addr(req_addr), .kind(req_kind),
        .exc_pulse(exc_pulse), .sticky(flt_sticky),
        .rec_addr(flt_addr), .rec_kind(flt_kind)
    );

    // R1: nothing reaches the bus without a core request
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> req_valid);
    // R5: supervisor requests always go through
    a_r5_super_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super) |-> bus_valid);
    // R6: a refused request is followed by the exception
    a_r6_refuse_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_valid) |=> exc_pulse);
endmodule

// File: tb/fence_guard_bench.sv
module fence_guard_bench;
    localparam int AW = 32;
    localparam int NIO = 2;
    localparam int SEL_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_super = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_kind = 2'b00;
    logic bus_valid, exc_pulse, flt_sticky;
    logic [AW-1:0] bus_addr, flt_addr;
    logic [1:0] flt_kind;
    logic cfg_we = 1'b0, cfg_priv = 1'b0;
    logic [SEL_W-1:0] cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fence_guard #(.AW(AW), .NIO(NIO), .SEL_W(SEL_W)) u_fence_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .req_super(req_super),
        .bus_valid(bus_valid), .bus_addr(bus_addr),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .exc_pulse(exc_pulse), .flt_sticky(flt_sticky), .flt_addr(flt_addr), .flt_kind(flt_kind)
    );

    // {addr, super, kind, expected bus_valid}
    localparam logic [35:0] VEC [10] = '{
        {32'h0000_1000, 1'b0, 2'b00, 1'b1},
        {32'h0000_1FFF, 1'b0, 2'b01, 1'b1},
        {32'h0000_2000, 1'b0, 2'b00, 1'b0},
        {32'h0000_0FFF, 1'b0, 2'b10, 1'b0},
        {32'h8000_0000, 1'b0, 2'b01, 1'b1},
        {32'h8000_00FF, 1'b0, 2'b00, 1'b1},
        {32'h8000_0100, 1'b0, 2'b00, 1'b0},
        {32'h9000_0000, 1'b0, 2'b00, 1'b0},
        {32'h9000_0000, 1'b1, 2'b01, 1'b1},
        {32'hFFFF_FFFF, 1'b1, 2'b10, 1'b1}
    };

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg(input logic priv, input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_sel = SEL_W'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
    endtask

    // drive a request for one cycle; check bus side now and exception after the edge
    task automatic access(input string req, input logic [AW-1:0] a, input logic sup,
                          input logic [1:0] k, input logic exp_ok);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_super = sup; req_kind = k;
        #1;
        check(req, {31'd0, bus_valid}, {31'd0, exp_ok});
        check("R1", bus_addr, a);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, "/R6 exc"}, {31'd0, exc_pulse}, {31'd0, ~exp_ok});
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R3)
        check("R3 sticky", {31'd0, flt_sticky}, 32'd0);
        check("R3 exc", {31'd0, exc_pulse}, 32'd0);
        access("R3 empty after reset", 32'h0, 1'b0, 2'b00, 1'b0);
        check("R7 first record", flt_addr, 32'h0);
        cfg(1'b1, 3, '0);
        check("R8 release", {31'd0, flt_sticky}, 32'd0);

        // configure
        cfg(1'b1, 0, 32'h0000_1000);
        cfg(1'b1, 1, 32'h0000_2000);
        cfg(1'b1, 4, 32'h8000_0000);
        cfg(1'b1, 5, 32'h8000_0100);
        cfg(1'b1, 6, 32'h9000_0000);
        cfg(1'b1, 7, 32'h9000_0010);
        cfg(1'b1, 2, 32'h1);

        // table walk (R2, R4, R5, R6)
        for (int i = 0; i < 10; i++) begin
            access("R2/R4/R5 table", VEC[i][35:4], VEC[i][3], VEC[i][2:1], VEC[i][0]);
        end

        // R7: first fault held, later fault ignored
        cfg(1'b1, 3, '0);
        access("R7 fault A", 32'h0000_3000, 1'b0, 2'b01, 1'b0);
        access("R7 fault B", 32'h0000_4000, 1'b0, 2'b00, 1'b0);
        check("R7 addr", flt_addr, 32'h0000_3000);
        check("R7 kind", {30'd0, flt_kind}, 32'd1);
        check("R7 sticky", {31'd0, flt_sticky}, 32'd1);
        @(negedge clk);
        check("R6 single pulse", {31'd0, exc_pulse}, 32'd0);

        // R9: unprivileged clear and fence write ignored
        cfg(1'b0, 3, '0);
        check("R9 clear ignored", {31'd0, flt_sticky}, 32'd1);
        cfg(1'b0, 1, 32'h0);
        access("R9 fence kept", 32'h0000_1800, 1'b0, 2'b00, 1'b1);

        // R8: clear and violation in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 3'd3;
        req_valid = 1'b1; req_addr = 32'h0000_5000; req_super = 1'b0; req_kind = 2'b10;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
        check("R8 recapture sticky", {31'd0, flt_sticky}, 32'd1);
        check("R8 recapture addr", flt_addr, 32'h0000_5000);
        check("R8 recapture kind", {30'd0, flt_kind}, 32'd2);
        cfg(1'b1, 3, '0);
        check("R8 clear alone", {31'd0, flt_sticky}, 32'd0);

        // R10: write and request in one cycle -> old fence; next cycle -> new
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 3'd2; cfg_wdata = 32'h3;
        req_valid = 1'b1; req_addr = 32'h9000_0008; req_super = 1'b0; req_kind = 2'b00;
        #1;
        check("R10 old fence used", {31'd0, bus_valid}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
        #1;
        check("R10 new fence used", {31'd0, bus_valid}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;

        // R3: empty pair matches nothing; R4 disabled window
        cfg(1'b1, 7, 32'h9000_0000);
        access("R3 empty io pair", 32'h9000_0000, 1'b0, 2'b00, 1'b0);
        cfg(1'b1, 2, 32'h0);
        access("R4 disabled window", 32'h8000_0010, 1'b0, 2'b01, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule